// File: doc/BRIEF.md
# Four-Entry Page Translator

This block maps a 32-bit virtual address onto a physical address through a small table of four entries. The table is fully associative, has 4 KB pages, and software loads it. Every entry holds two 32-bit words. The first is a tag: the virtual page number, with the process identifier placed at bit 1 and above and a store-permission flag in bit 0. The second is the physical page base. Software fills the table through a memory-mapped write window. A process-identifier register and a fault-page register sit beside the table on the same bus.

On each request the translator uses the request inputs (virtual address, user-mode flag, store flag) and the process identifier held in its own register. It returns an address in the same cycle. If the process identifier is zero or the request is not in user mode, the address passes through unchanged. Otherwise a matching entry supplies the physical page. When no entry matches, the block:
- raises a miss pulse in that cycle;
- records the page of the faulting address;
- sets an interrupt flag.

A later write anywhere in the table window clears the interrupt flag.

Top module: `xlate_unit`

## Requirements
- R1: After reset the process-identifier register reads 0, the fault register reads 0, irq_o is low, and a request leaves the address unchanged with no miss.
- R2: When the process identifier is 0 or xl_user is low, xl_paddr equals xl_vaddr and xl_miss stays low, whatever the table holds.
- R3: An entry matches when its tag with bit 0 forced to 0 equals the virtual address with its low 12 bits zeroed, ORed with the process identifier shifted left by one. On a hit, xl_paddr is the entry's physical word ORed with xl_vaddr[11:0].
- R4: For a store (xl_write high), a matching entry also needs tag bit 0 set. For a load, tag bit 0 is ignored.
- R5: When several entries match, the one with the lowest index supplies the physical word.
- R6: A translated request that matches no entry drives xl_miss high in the same cycle, with xl_paddr equal to xl_vaddr. From the next cycle, the fault register holds xl_vaddr with its low 12 bits zeroed and irq_o is high.
- R7: A bus write at 0x200000a0 + 8*i loads the tag of entry i, and a write at 0x200000a4 + 8*i loads its physical word (i = 0..3). The new contents take effect from the next cycle. Any write in this window clears irq_o in the next cycle.
- R8: The process-identifier register is written and read at 0x20000080 (low 8 bits kept, upper bits read 0). The fault register is read at 0x20000090, and bus writes there have no effect.
- R9: If a miss and a table write fall in the same cycle, the request is judged against the old table contents, irq_o ends high, and the fault page is recorded.
- R10: With xl_req low, xl_miss stays low and neither the fault register nor irq_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xl_req | input | 1 | Translation request valid |
| xl_vaddr | input | 32 | Virtual address |
| xl_user | input | 1 | Request issued in user mode |
| xl_write | input | 1 | Request is a store |
| xl_paddr | output | 32 | Translated address (combinational) |
| xl_miss | output | 1 | No matching entry, same-cycle pulse |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 32 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| irq_o | output | 1 | Translation-fault interrupt flag |

## Verification
Two events can land on the same clock edge:
- a table write, which clears the interrupt flag and changes an entry;
- a translation miss, which sets the flag and records the fault page.

The bench provokes this by storing, in the same cycle as a rejected store, a tag that would grant that store permission. It then checks four things: the miss is reported that cycle; irq_o is high afterwards; the fault register holds the faulting page; and the very next identical store hits.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
#(
    parameter int unsigned ENTRIES    = 4,
    parameter int unsigned PID_W      = 8,
    parameter logic [31:0] PID_ADDR   = 32'h2000_0080,
    parameter logic [31:0] FAULT_ADDR = 32'h2000_0090,
    parameter logic [31:0] TBL_ADDR   = 32'h2000_00a0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  word_t                     bus_addr,
    input  word_t                     bus_wdata,
    output word_t                     bus_rdata,
    input  logic                      miss_ev,
    input  word_t                     miss_page,
    output logic [PID_W-1:0]          pid_o,
    output logic [ENTRIES-1:0][31:0]  tag_o,
    output logic [ENTRIES-1:0][31:0]  phys_o,
    output word_t                     fault_o,
    output logic                      irq_o
);
    localparam logic [31:0] TBL_BYTES = 32'(ENTRIES * 8);

    typedef struct packed {
        logic [ENTRIES-1:0][31:0] tag;
        logic [ENTRIES-1:0][31:0] phys;
        logic [PID_W-1:0]         pid;
        logic [31:0]              fault;
        logic                     irq;
    } state_t;

    state_t st_d, st_q;
    word_t  tbl_off;
    logic   tbl_hit;

    assign tbl_off = bus_addr - TBL_ADDR;
    assign tbl_hit = (bus_addr >= TBL_ADDR) && (tbl_off < TBL_BYTES);

    always_comb begin
        st_d = st_q;
        if (bus_we && tbl_hit) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                if (tbl_off[31:3] == 29'(i)) begin
                    if (tbl_off[2]) st_d.phys[i] = bus_wdata;
                    else            st_d.tag[i]  = bus_wdata;
                end
            end
            st_d.irq = 1'b0;
        end
        if (bus_we && (bus_addr == PID_ADDR)) begin
            st_d.pid = bus_wdata[PID_W-1:0];
        end
        // a fault raised in the same cycle outranks the clear
        if (miss_ev) begin
            st_d.fault = miss_page;
            st_d.irq   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == PID_ADDR)        bus_rdata = {{(32-PID_W){1'b0}}, st_q.pid};
        else if (bus_addr == FAULT_ADDR) bus_rdata = st_q.fault;
    end

    assign pid_o   = st_q.pid;
    assign tag_o   = st_q.tag;
    assign phys_o  = st_q.phys;
    assign fault_o = st_q.fault;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/xlate_cam.sv
module xlate_cam #(
    parameter int unsigned ENTRIES   = 4,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PID_W     = 8
) (
    input  logic [ENTRIES-1:0][31:0] tag_i,
    input  logic [31-PAGE_BITS:0]    vpage_i,
    input  logic [PID_W-1:0]         pid_i,
    input  logic                     store_i,
    output logic [ENTRIES-1:0]       hit_o
);
    logic [31:0] key;
    assign key = {vpage_i, {PAGE_BITS{1'b0}}} | {{(31-PID_W){1'b0}}, pid_i, 1'b0};

    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ent
        logic tag_eq;
        assign tag_eq   = ({tag_i[g][31:1], 1'b0} == key);
        assign hit_o[g] = tag_eq && (!store_i || tag_i[g][0]);
    end
endmodule

// File: rtl/xlate_pick.sv
module xlate_pick #(
    parameter int unsigned ENTRIES = 4
) (
    input  logic [ENTRIES-1:0] hit_i,
    output logic [ENTRIES-1:0] grant_o,
    output logic               any_o
);
    always_comb begin
        logic seen;
        seen    = 1'b0;
        grant_o = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            grant_o[i] = hit_i[i] && !seen;
            seen       = seen || hit_i[i];
        end
    end
    assign any_o = |hit_i;
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
    import xlate_pkg::*;
#(
    parameter int unsigned ENTRIES    = 4,
    parameter int unsigned PAGE_BITS  = 12,
    parameter int unsigned PID_W      = 8,
    parameter logic [31:0] PID_ADDR   = 32'h2000_0080,
    parameter logic [31:0] FAULT_ADDR = 32'h2000_0090,
    parameter logic [31:0] TBL_ADDR   = 32'h2000_00a0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  xl_req,
    input  word_t xl_vaddr,
    input  logic  xl_user,
    input  logic  xl_write,
    output word_t xl_paddr,
    output logic  xl_miss,
    input  logic  bus_we,
    input  word_t bus_addr,
    input  word_t bus_wdata,
    output word_t bus_rdata,
    output logic  irq_o
);
    logic [PID_W-1:0]         pid_q;
    logic [ENTRIES-1:0][31:0] tag_q;
    logic [ENTRIES-1:0][31:0] phys_q;
    word_t                    fault_q;
    logic [ENTRIES-1:0]       hit;
    logic [ENTRIES-1:0]       grant;
    logic                     any_hit;
    logic                     bypass;
    word_t                    phys_sel;
    word_t                    miss_page;

    assign bypass    = (pid_q == '0) || !xl_user;
    assign xl_miss   = xl_req && !bypass && !any_hit;
    assign miss_page = {xl_vaddr[31:PAGE_BITS], {PAGE_BITS{1'b0}}};

    xlate_regs #(
        .ENTRIES(ENTRIES), .PID_W(PID_W),
        .PID_ADDR(PID_ADDR), .FAULT_ADDR(FAULT_ADDR), .TBL_ADDR(TBL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .miss_ev(xl_miss), .miss_page(miss_page),
        .pid_o(pid_q), .tag_o(tag_q), .phys_o(phys_q), .fault_o(fault_q), .irq_o(irq_o)
    );

    xlate_cam #(.ENTRIES(ENTRIES), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)) u_cam (
        .tag_i(tag_q), .vpage_i(xl_vaddr[31:PAGE_BITS]), .pid_i(pid_q),
        .store_i(xl_write), .hit_o(hit)
    );

    xlate_pick #(.ENTRIES(ENTRIES)) u_pick (
        .hit_i(hit), .grant_o(grant), .any_o(any_hit)
    );

    always_comb begin
        phys_sel = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (grant[i]) phys_sel = phys_sel | phys_q[i];
        end
    end

    always_comb begin
        if (!bypass && any_hit) xl_paddr = phys_sel | {{(32-PAGE_BITS){1'b0}}, xl_vaddr[PAGE_BITS-1:0]};
        else                    xl_paddr = xl_vaddr;
    end
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
    parameter int unsigned ENTRIES   = 4,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PID_W     = 8,
    parameter logic [31:0] TBL_ADDR  = 32'h2000_00a0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xl_req,
    input logic [31:0]       xl_vaddr,
    input logic              xl_user,
    input logic [31:0]       xl_paddr,
    input logic              xl_miss,
    input logic              bus_we,
    input logic [31:0]       bus_addr,
    input logic              irq_o,
    input logic [PID_W-1:0]  pid_cur,
    input logic [31:0]       fault_cur
);
    localparam logic [31:0] TBL_END = TBL_ADDR + 32'(ENTRIES * 8);
    logic tbl_wr;
    assign tbl_wr = bus_we && (bus_addr >= TBL_ADDR) && (bus_addr < TBL_END);

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && (pid_cur == '0 || !xl_user)) |-> (xl_paddr == xl_vaddr && !xl_miss)); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |-> (xl_paddr[PAGE_BITS-1:0] == xl_vaddr[PAGE_BITS-1:0])); // R3
    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        xl_miss |-> (xl_paddr == xl_vaddr)); // R6
    AST_MISS_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        xl_miss |=> (irq_o && fault_cur == {$past(xl_vaddr[31:PAGE_BITS]), {PAGE_BITS{1'b0}}})); // R6
    AST_TBL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && !xl_miss) |=> !irq_o); // R7
    AST_BOTH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && xl_miss) |=> irq_o); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |-> !xl_miss); // R10
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_miss |=> $stable(fault_cur)); // R10
endmodule

bind xlate_unit xlate_chk #(
    .ENTRIES(ENTRIES), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W), .TBL_ADDR(TBL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_user(xl_user),
    .xl_paddr(xl_paddr), .xl_miss(xl_miss), .bus_we(bus_we), .bus_addr(bus_addr),
    .irq_o(irq_o), .pid_cur(pid_q), .fault_cur(fault_q)
);

// File: tb/sim_xlate_unit.sv
`timescale 1ns/1ps
module sim_xlate_unit;
    localparam logic [31:0] A_PID   = 32'h2000_0080;
    localparam logic [31:0] A_FAULT = 32'h2000_0090;
    localparam logic [31:0] A_TBL   = 32'h2000_00a0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xl_req = 1'b0, xl_user = 1'b0, xl_write = 1'b0;
    logic [31:0] xl_vaddr = '0;
    logic [31:0] xl_paddr;
    logic xl_miss;
    logic bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlate_unit u0 (
        .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_user(xl_user),
        .xl_write(xl_write), .xl_paddr(xl_paddr), .xl_miss(xl_miss), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0]  pid;
        logic        user;
        logic        wr;
        logic [31:0] va;
        logic [31:0] pa;
        logic        miss;
    } vec_t;

    // table: e0 tag 00400007/phys 00010000, e1 00401006/00020000,
    //        e2 0040000B/00030000, e3 00400007/00040000 (duplicate of e0)
    localparam vec_t VECS [10] = '{
        '{8'd3, 1'b1, 1'b0, 32'h0040_0123, 32'h0001_0123, 1'b0}, // R3 R5 load hit, e0 beats e3
        '{8'd3, 1'b1, 1'b1, 32'h0040_0FFC, 32'h0001_0FFC, 1'b0}, // R4 store on writable entry
        '{8'd3, 1'b1, 1'b0, 32'h0040_1010, 32'h0002_0010, 1'b0}, // R4 load ignores bit 0
        '{8'd3, 1'b1, 1'b1, 32'h0040_1010, 32'h0040_1010, 1'b1}, // R4 R6 store rejected
        '{8'd5, 1'b1, 1'b0, 32'h0040_0ABC, 32'h0003_0ABC, 1'b0}, // R3 other process
        '{8'd5, 1'b1, 1'b0, 32'h0040_1000, 32'h0040_1000, 1'b1}, // R6 unmapped page
        '{8'd3, 1'b0, 1'b1, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R2 kernel mode
        '{8'd0, 1'b1, 1'b1, 32'h0099_9999, 32'h0099_9999, 1'b0}, // R2 process id zero
        '{8'd4, 1'b1, 1'b0, 32'h0040_0000, 32'h0040_0000, 1'b1}, // R3 wrong process id
        '{8'd3, 1'b1, 1'b0, 32'h0040_0FFF, 32'h0001_0FFF, 1'b0}  // R3 top offset
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic xlate(input logic u, input logic w, input logic [31:0] va,
                         output logic [31:0] pa, output logic m);
        xl_req = 1'b1; xl_user = u; xl_write = w; xl_vaddr = va;
        #2;
        pa = xl_paddr; m = xl_miss;
        @(negedge clk);
        xl_req = 1'b0; xl_user = 1'b0; xl_write = 1'b0; xl_vaddr = '0;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        if (!done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, pa;
        logic m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_PID, rd);   check("R1 pid", rd, 32'h0);
        bus_read(A_FAULT, rd); check("R1 fault", rd, 32'h0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        xlate(1'b1, 1'b0, 32'h0040_0123, pa, m);
        check("R1 paddr", pa, 32'h0040_0123);
        check("R1 miss", {31'd0, m}, 32'd0);

        // R7 load the table
        bus_write(A_TBL + 32'h00, 32'h0040_0007); bus_write(A_TBL + 32'h04, 32'h0001_0000);
        bus_write(A_TBL + 32'h08, 32'h0040_1006); bus_write(A_TBL + 32'h0C, 32'h0002_0000);
        bus_write(A_TBL + 32'h10, 32'h0040_000B); bus_write(A_TBL + 32'h14, 32'h0003_0000);
        bus_write(A_TBL + 32'h18, 32'h0040_0007); bus_write(A_TBL + 32'h1C, 32'h0004_0000);

        for (int i = 0; i < 10; i++) begin
            bus_write(A_PID, {24'd0, VECS[i].pid});
            xlate(VECS[i].user, VECS[i].wr, VECS[i].va, pa, m);
            check($sformatf("R3/R4 vec%0d paddr", i), pa, VECS[i].pa);
            check($sformatf("R6 vec%0d miss", i), {31'd0, m}, {31'd0, VECS[i].miss});
        end

        // R6 fault page and irq after a miss
        bus_write(A_PID, 32'd3);
        xlate(1'b1, 1'b0, 32'h0077_7ABC, pa, m);
        check("R6 miss pulse", {31'd0, m}, 32'd1);
        bus_read(A_FAULT, rd); check("R6 fault page", rd, 32'h0077_7000);
        check("R6 irq set", {31'd0, irq_o}, 32'd1);

        // R8 fault register ignores writes, pid reads back masked
        bus_write(A_FAULT, 32'hDEAD_BEEF);
        bus_read(A_FAULT, rd); check("R8 fault write ignored", rd, 32'h0077_7000);
        bus_write(A_PID, 32'hFFFF_FF5A);
        bus_read(A_PID, rd); check("R8 pid readback", rd, 32'h0000_005A);
        bus_write(A_PID, 32'd3);

        // R10 idle request changes nothing
        xl_req = 1'b0; xl_user = 1'b1; xl_vaddr = 32'h00AB_C000; #2;
        check("R10 no miss when idle", {31'd0, xl_miss}, 32'd0);
        @(negedge clk); xl_user = 1'b0; xl_vaddr = '0;
        bus_read(A_FAULT, rd); check("R10 fault unchanged", rd, 32'h0077_7000);
        check("R10 irq unchanged", {31'd0, irq_o}, 32'd1);

        // R7 table write clears irq
        bus_write(A_TBL + 32'h1C, 32'h0004_0000);
        check("R7 irq cleared", {31'd0, irq_o}, 32'd0);

        // R9 miss and table write in the same cycle
        bus_we = 1'b1; bus_addr = A_TBL + 32'h08; bus_wdata = 32'h0040_1007;
        xlate(1'b1, 1'b1, 32'h0040_1010, pa, m);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        check("R9 old contents miss", {31'd0, m}, 32'd1);
        check("R9 irq wins", {31'd0, irq_o}, 32'd1);
        bus_read(A_FAULT, rd); check("R9 fault page", rd, 32'h0040_1000);
        xlate(1'b1, 1'b1, 32'h0040_1010, pa, m);
        check("R9 new entry hits", pa, 32'h0002_0010);
        check("R9 new entry no miss", {31'd0, m}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule